// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains the chain of extended capability headers kept in a 4 KB configuration-space RAM. Each header is a 32-bit word carrying a capability ID, a version and a 12-bit byte pointer to the next header. The chain always begins at byte 256, and a pointer of zero ends it. The block serves two kinds of command, one at a time. A lookup follows the chain until it reaches a header with the requested ID. It returns the offset of that header and the offset of the header before it, or a miss. An append adds a new header at a given offset. At offset 256 it rewrites the head in place. Anywhere else it first walks to the last header, points that header at the new one, and then writes the new header.

The RAM is reached through one 32-bit port. A read issued in one cycle returns its data in the next. Writes take effect at the clock edge. A done pulse completes every command and carries its result flags and offsets. These result outputs hold their values until the next command completes. The block raises an error if it meets a corrupt pointer, if the walk is too long, or if it is asked to append to an empty chain away from the head.

Top module: `extCapWalker`

## Requirements
- R1: After reset, busy, done, found, err, rejected, ramWe and ramRe are all 0.
- R2: A header word of all zero at byte 256 means the chain is empty. A lookup of any ID then completes with found=0, resOffset=0 and resPrev=0.
- R3: A header holds the ID in bits [15:0], the version in bits [19:16] and the next pointer in bits [31:20]. A lookup of a non-zero ID stops at the first header along the chain whose ID equals it. It reports found=1, resOffset set to that header's byte offset, and resPrev set to the offset of the header before it (0 when the match is at 256).
- R4: A lookup that reaches a header whose next pointer is 0 without a match reports found=0, resOffset=0 and resPrev set to the offset of that last header. ID 0 never matches, so a lookup of ID 0 always ends at the last header.
- R5: Let n be the number of headers a walk reads. A lookup or a failing walk pulses done exactly 2n cycles after the edge that accepts it. busy is high from the edge after acceptance until done rises, and it is low while done is high. The RAM is written only while busy is high.
- R6: An append at offset 256 reads the head and writes {old next pointer, version, ID} back to 256. It reports resOffset=256 and resPrev=0, with done 2 cycles after acceptance.
- R7: An append at any other offset walks to the last header. It rewrites only bits [31:20] of that header with the new offset, then writes {0, version, ID} at the new offset. It reports resOffset equal to the new offset and resPrev equal to the old last header, with done 2n+1 cycles after acceptance.
- R8: An append whose offset is below 256, whose offset is not a multiple of 4, whose size is below 8, or whose offset plus size is 4096 or more is rejected. done and rejected rise at the accepting edge, busy never rises, and the RAM is not written.
- R9: A walk that meets a non-zero next pointer that is not a multiple of 4, is below 256 or is above 4088 ends with err=1, found=0, resOffset=0 and resPrev=0, and nothing is written.
- R10: A walk that would read more than 1024 headers ends with err=1 when the 1025th header is read. This catches a looped chain.
- R11: An append away from 256 on an empty chain ends with err=1 after one header read (done 2 cycles after acceptance) and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request, taken when busy is low |
| cmdOp | input | 1 | 0 lookup, 1 append |
| cmdId | input | 16 | Capability ID to find or to write |
| cmdVer | input | 4 | Version written by an append |
| cmdOffset | input | 12 | Byte offset of the header to append |
| cmdSize | input | 13 | Byte size of the region being appended |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Lookup matched |
| err | output | 1 | Walk failed (bad pointer, loop, empty chain on append) |
| rejected | output | 1 | Append arguments refused |
| resOffset | output | 12 | Matched or appended header offset |
| resPrev | output | 12 | Offset of the preceding header |
| ramRe | output | 1 | RAM read strobe |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | 12 | RAM byte address, word aligned |
| ramWdata | output | 32 | RAM write data |
| ramRdata | input | 32 | RAM read data, one cycle after the read |

## Verification
Each header the walk reads costs two cycles, one to address the RAM and one to judge the returned word. So a walk of n headers ends 2n edges after acceptance, a tail append ends one edge later, and a rejection completes on the accepting edge itself. The bench models the chain in its own RAM array and counts n from that model. It drives each command at a falling edge, then counts falling edges until done is seen. The measured count is compared against the latency expected for that n, and the results and RAM words are checked only in that same cycle, when the next command has not yet started.

// File: rtl/extCapPkg.sv
package extCapPkg;
  localparam int HdrW  = 32;
  localparam int IdW   = 16;
  localparam int VerW  = 4;
  localparam int PtrW  = 12;
  localparam int SizeW = PtrW + 1;

  typedef enum logic [1:0] {StIdle, StRead, StCheck, StWrNew} walkState_e;

  typedef struct packed {
    logic latchCmd;
    logic rdEn;
    logic advance;
    logic wrHeadKeep;
    logic wrTailLink;
    logic wrNewHdr;
    logic finFound;
    logic finMiss;
    logic finAppend;
    logic finError;
    logic finReject;
  } ctrlStrobe_t;

  typedef struct packed {
    logic argsBad;
    logic opAppend;
    logic appendAtHead;
    logic headEmpty;
    logic idMatch;
    logic atTail;
    logic nextBad;
    logic visitsOver;
  } walkFlag_t;
endpackage

// File: rtl/extCapData.sv
module extCapData
  import extCapPkg::*;
#(
  parameter int HeadOff    = 256,
  parameter int SpaceBytes = 4096,
  parameter int MaxVisits  = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic             cmdOp,
  input  logic [IdW-1:0]   cmdId,
  input  logic [VerW-1:0]  cmdVer,
  input  logic [PtrW-1:0]  cmdOffset,
  input  logic [SizeW-1:0] cmdSize,
  input  logic [HdrW-1:0]  ramRdata,
  output walkFlag_t        flags,
  output logic             ramRe,
  output logic             ramWe,
  output logic [PtrW-1:0]  ramAddr,
  output logic [HdrW-1:0]  ramWdata,
  output logic             done,
  output logic             found,
  output logic             err,
  output logic             rejected,
  output logic [PtrW-1:0]  resOffset,
  output logic [PtrW-1:0]  resPrev
);
  localparam int VisitW = $clog2(MaxVisits + 1);
  localparam logic [PtrW-1:0] HeadPtr = PtrW'(HeadOff);
  localparam logic [PtrW-1:0] MaxPtr  = PtrW'(SpaceBytes - 8);
  localparam int NextLsb = HdrW - PtrW;

  logic              opAppend;
  logic [IdW-1:0]    idReg;
  logic [VerW-1:0]   verReg;
  logic [PtrW-1:0]   offReg;
  logic [PtrW-1:0]   curPtr;
  logic [PtrW-1:0]   prevPtr;
  logic [VisitW-1:0] visitCnt;

  logic [PtrW-1:0]   nextField;
  logic [IdW-1:0]    hdrId;
  logic [IdW-1:0]    searchKey;
  logic [PtrW+1:0]   endSum;

  assign nextField = ramRdata[HdrW-1:NextLsb];
  assign hdrId     = ramRdata[IdW-1:0];
  assign searchKey = opAppend ? '0 : idReg;
  assign endSum    = {2'b00, cmdOffset} + {1'b0, cmdSize};

  always_comb begin
    flags.argsBad = (cmdOffset < HeadPtr) || (cmdOffset[1:0] != 2'b00) ||
                    (cmdSize < SizeW'(8)) || (endSum >= (PtrW+2)'(SpaceBytes));
    flags.opAppend     = opAppend;
    flags.appendAtHead = (offReg == HeadPtr);
    flags.headEmpty    = (curPtr == HeadPtr) && (ramRdata == '0);
    flags.idMatch      = (searchKey != '0) && (hdrId == searchKey);
    flags.atTail       = (nextField == '0);
    flags.nextBad      = (nextField[1:0] != 2'b00) || (nextField < HeadPtr) ||
                         (nextField > MaxPtr);
    flags.visitsOver   = (visitCnt == VisitW'(MaxVisits));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAppend <= 1'b0;
      idReg    <= '0;
      verReg   <= '0;
      offReg   <= '0;
      curPtr   <= HeadPtr;
      prevPtr  <= '0;
      visitCnt <= '0;
    end else if (strb.latchCmd) begin
      opAppend <= cmdOp;
      idReg    <= cmdId;
      verReg   <= cmdVer;
      offReg   <= cmdOffset;
      curPtr   <= HeadPtr;
      prevPtr  <= '0;
      visitCnt <= '0;
    end else if (strb.advance) begin
      prevPtr  <= curPtr;
      curPtr   <= nextField;
      visitCnt <= visitCnt + 1'b1;
    end
  end

  always_comb begin
    ramRe    = strb.rdEn;
    ramWe    = strb.wrHeadKeep | strb.wrTailLink | strb.wrNewHdr;
    ramAddr  = strb.wrNewHdr ? offReg : curPtr;
    ramWdata = '0;
    if (strb.wrHeadKeep) ramWdata = {nextField, verReg, idReg};
    else if (strb.wrTailLink) ramWdata = {offReg, ramRdata[NextLsb-1:0]};
    else if (strb.wrNewHdr) ramWdata = {{PtrW{1'b0}}, verReg, idReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done      <= 1'b0;
      found     <= 1'b0;
      err       <= 1'b0;
      rejected  <= 1'b0;
      resOffset <= '0;
      resPrev   <= '0;
    end else begin
      done <= strb.finFound | strb.finMiss | strb.finAppend | strb.finError | strb.finReject;
      if (strb.finFound) begin
        {found, err, rejected} <= 3'b100;
        resOffset <= curPtr;
        resPrev   <= prevPtr;
      end else if (strb.finMiss) begin
        {found, err, rejected} <= 3'b000;
        resOffset <= '0;
        resPrev   <= flags.headEmpty ? '0 : curPtr;
      end else if (strb.finAppend) begin
        {found, err, rejected} <= 3'b000;
        resOffset <= offReg;
        resPrev   <= flags.appendAtHead ? '0 : curPtr;
      end else if (strb.finError) begin
        {found, err, rejected} <= 3'b010;
        resOffset <= '0;
        resPrev   <= '0;
      end else if (strb.finReject) begin
        {found, err, rejected} <= 3'b001;
        resOffset <= '0;
        resPrev   <= '0;
      end
    end
  end
endmodule

// File: rtl/extCapCtrl.sv
module extCapCtrl
  import extCapPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdOp,
  input  walkFlag_t   flags,
  output ctrlStrobe_t strb,
  output logic        busy
);
  walkState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNxt;
  end

  assign busy = (state != StIdle);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      StIdle: begin
        if (cmdValid) begin
          if (cmdOp && flags.argsBad) begin
            strb.finReject = 1'b1;
          end else begin
            strb.latchCmd = 1'b1;
            stateNxt      = StRead;
          end
        end
      end
      StRead: begin
        strb.rdEn = 1'b1;
        stateNxt  = StCheck;
      end
      StCheck: begin
        stateNxt = StIdle;
        if (flags.visitsOver) begin
          strb.finError = 1'b1;
        end else if (flags.opAppend) begin
          if (flags.appendAtHead) begin
            strb.wrHeadKeep = 1'b1;
            strb.finAppend  = 1'b1;
          end else if (flags.headEmpty) begin
            strb.finError = 1'b1;
          end else if (flags.atTail) begin
            strb.wrTailLink = 1'b1;
            stateNxt        = StWrNew;
          end else if (flags.nextBad) begin
            strb.finError = 1'b1;
          end else begin
            strb.advance = 1'b1;
            stateNxt     = StRead;
          end
        end else begin
          if (flags.headEmpty) begin
            strb.finMiss = 1'b1;
          end else if (flags.idMatch) begin
            strb.finFound = 1'b1;
          end else if (flags.atTail) begin
            strb.finMiss = 1'b1;
          end else if (flags.nextBad) begin
            strb.finError = 1'b1;
          end else begin
            strb.advance = 1'b1;
            stateNxt     = StRead;
          end
        end
      end
      StWrNew: begin
        strb.wrNewHdr  = 1'b1;
        strb.finAppend = 1'b1;
        stateNxt       = StIdle;
      end
      default: stateNxt = StIdle;
    endcase
  end
endmodule

// File: rtl/extCapWalker.sv
module extCapWalker
  import extCapPkg::*;
#(
  parameter int HeadOff    = 256,
  parameter int SpaceBytes = 4096,
  parameter int MaxVisits  = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdOp,
  input  logic [IdW-1:0]   cmdId,
  input  logic [VerW-1:0]  cmdVer,
  input  logic [PtrW-1:0]  cmdOffset,
  input  logic [SizeW-1:0] cmdSize,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic             err,
  output logic             rejected,
  output logic [PtrW-1:0]  resOffset,
  output logic [PtrW-1:0]  resPrev,
  output logic             ramRe,
  output logic             ramWe,
  output logic [PtrW-1:0]  ramAddr,
  output logic [HdrW-1:0]  ramWdata,
  input  logic [HdrW-1:0]  ramRdata
);
  ctrlStrobe_t strb;
  walkFlag_t   flags;

  extCapCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .flags    (flags),
    .strb     (strb),
    .busy     (busy)
  );

  extCapData #(
    .HeadOff    (HeadOff),
    .SpaceBytes (SpaceBytes),
    .MaxVisits  (MaxVisits)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdOp     (cmdOp),
    .cmdId     (cmdId),
    .cmdVer    (cmdVer),
    .cmdOffset (cmdOffset),
    .cmdSize   (cmdSize),
    .ramRdata  (ramRdata),
    .flags     (flags),
    .ramRe     (ramRe),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata),
    .done      (done),
    .found     (found),
    .err       (err),
    .rejected  (rejected),
    .resOffset (resOffset),
    .resPrev   (resPrev)
  );
endmodule

// File: rtl/extCapWalkerChk.sv
module extCapWalkerChk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        busy,
  input logic        done,
  input logic        found,
  input logic        err,
  input logic        rejected,
  input logic [11:0] resOffset,
  input logic        ramWe,
  input logic [11:0] ramAddr
);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> busy);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));

  // R7
  write_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr[1:0] == 2'b00) && (ramAddr >= 12'd256));

  // R3
  found_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (resOffset >= 12'd256) && (resOffset[1:0] == 2'b00));

  // R8
  reject_quick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && rejected) |-> !$past(busy));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({found, err, rejected}) <= 1));
endmodule

bind extCapWalker extCapWalkerChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .busy      (busy),
  .done      (done),
  .found     (found),
  .err       (err),
  .rejected  (rejected),
  .resOffset (resOffset),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr)
);

// File: tb/sim_extCapWalker.sv
`timescale 1ns/1ps
module sim_extCapWalker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdOp = 1'b0;
  logic [15:0] cmdId = '0;
  logic [3:0]  cmdVer = '0;
  logic [11:0] cmdOffset = '0;
  logic [12:0] cmdSize = '0;
  logic        busy, done, found, err, rejected, ramRe, ramWe;
  logic [11:0] resOffset, resPrev, ramAddr;
  logic [31:0] ramWdata;
  logic [31:0] ramRdata = '0;
  logic [31:0] mem [1024];

  int nChk = 0;
  int nErr = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  extCapWalker u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdId(cmdId),
    .cmdVer(cmdVer), .cmdOffset(cmdOffset), .cmdSize(cmdSize), .busy(busy),
    .done(done), .found(found), .err(err), .rejected(rejected),
    .resOffset(resOffset), .resPrev(resPrev), .ramRe(ramRe), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  always @(posedge clk) begin
    if (ramWe) mem[ramAddr[11:2]] <= ramWdata;
    ramRdata <= mem[ramAddr[11:2]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nErr = nErr + 1;
      nChk = nChk + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk = nChk + 1;
    if (act !== exp) begin
      nErr = nErr + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  function automatic void gWalk(input logic [15:0] key, output int off, output int prv,
                                output bit fnd, output bit er, output int vis);
    int cur = 256;
    int pv = 0;
    int nx;
    bit stop = 0;
    logic [31:0] h;
    off = 0; prv = 0; fnd = 0; er = 0; vis = 0;
    for (int g = 0; g < 2000 && !stop; g++) begin
      vis = vis + 1;
      if (vis > 1024) begin er = 1; stop = 1; end
      else begin
        h = mem[cur >> 2];
        nx = int'(h[31:20]);
        if (cur == 256 && h == 0) stop = 1;
        else if (key != 0 && h[15:0] == key) begin fnd = 1; off = cur; prv = pv; stop = 1; end
        else if (nx == 0) begin prv = cur; stop = 1; end
        else if (nx % 4 != 0 || nx < 256 || nx > 4088) begin er = 1; stop = 1; end
        else begin pv = cur; cur = nx; end
      end
    end
  endfunction

  task automatic runCmd(input logic op, input logic [15:0] id, input logic [3:0] ver,
                        input logic [11:0] off, input logic [12:0] size,
                        output int lat, output bit busyOk);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdId = id; cmdVer = ver; cmdOffset = off; cmdSize = size;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 0;
    busyOk = 1;
    while (!done && lat < 5000) begin
      if (!busy) busyOk = 0;
      @(negedge clk);
      lat = lat + 1;
    end
    if (busy) busyOk = 0;
  endtask

  task automatic doSearch(input logic [15:0] key);
    int eOff, ePrv, eVis, lat;
    bit eFnd, eErr, bOk;
    string rq;
    gWalk(key, eOff, ePrv, eFnd, eErr, eVis);
    rq = eErr ? (eVis > 1024 ? "R10" : "R9") : eFnd ? "R3" : (ePrv == 0 ? "R2" : "R4");
    runCmd(1'b0, key, 4'd0, 12'd0, 13'd0, lat, bOk);
    chk(rq, "found", found, eFnd);
    chk(rq, "err", err, eErr);
    chk(rq, "resOffset", resOffset, eOff);
    chk(rq, "resPrev", resPrev, ePrv);
    chk("R5", "latency", lat, 2 * eVis);
    chk("R5", "busy window", bOk, 1);
  endtask

  task automatic doAppend(input logic [15:0] id, input logic [3:0] ver,
                          input logic [11:0] off, input logic [12:0] size);
    int eOff, ePrv, eVis, lat;
    bit eFnd, eErr, bOk;
    logic [31:0] head, tailOld, slotOld;
    head = mem[64];
    slotOld = mem[off >> 2];
    if (off < 256 || off[1:0] != 0 || size < 8 || int'(off) + int'(size) >= 4096) begin
      runCmd(1'b1, id, ver, off, size, lat, bOk);
      chk("R8", "rejected", rejected, 1);
      chk("R8", "latency", lat, 0);
      chk("R8", "head untouched", mem[64], head);
      chk("R8", "slot untouched", mem[off >> 2], slotOld);
    end else if (off == 256) begin
      runCmd(1'b1, id, ver, off, size, lat, bOk);
      chk("R6", "head word", mem[64], {head[31:20], ver, id});
      chk("R6", "resOffset", resOffset, 256);
      chk("R6", "resPrev", resPrev, 0);
      chk("R6", "latency", lat, 2);
    end else begin
      gWalk(16'd0, eOff, ePrv, eFnd, eErr, eVis);
      if (head == 0) begin
        runCmd(1'b1, id, ver, off, size, lat, bOk);
        chk("R11", "err", err, 1);
        chk("R11", "latency", lat, 2);
        chk("R11", "slot untouched", mem[off >> 2], slotOld);
      end else if (eErr) begin
        runCmd(1'b1, id, ver, off, size, lat, bOk);
        chk(eVis > 1024 ? "R10" : "R9", "err", err, 1);
        chk("R5", "latency", lat, 2 * eVis);
        chk("R9", "slot untouched", mem[off >> 2], slotOld);
      end else begin
        tailOld = mem[ePrv >> 2];
        runCmd(1'b1, id, ver, off, size, lat, bOk);
        chk("R7", "tail link", mem[ePrv >> 2], {off, tailOld[19:0]});
        chk("R7", "new header", mem[off >> 2], {12'd0, ver, id});
        chk("R7", "resOffset", resOffset, off);
        chk("R7", "resPrev", resPrev, ePrv);
        chk("R7", "latency", lat, 2 * eVis + 1);
        chk("R5", "busy window", bOk, 1);
      end
    end
  endtask

  initial begin
    int k, off, nxt, last;
    logic [15:0] id;
    void'($urandom(32'h5eed_1234));
    clearMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "flags", {found, err, rejected}, 0);
    chk("R1", "ram strobes", {ramWe, ramRe}, 0);
    rstN = 1'b1;

    // R2 empty chain
    doSearch(16'h0007);
    doSearch(16'h0000);
    // R11 append away from head on empty chain
    doAppend(16'h0003, 4'h1, 12'h200, 13'd16);
    // R6 append at head on empty chain, then on a chain keeping next
    doAppend(16'h0003, 4'h1, 12'h100, 13'd8);
    mem[64] = {12'h140, 4'h2, 16'h0009};
    mem[80] = {12'h000, 4'h1, 16'h000A};
    doAppend(16'h0011, 4'h5, 12'h100, 13'd64);
    doSearch(16'h000A);
    // R8 rejects
    doAppend(16'h0001, 4'h1, 12'h0FC, 13'd8);
    doAppend(16'h0001, 4'h1, 12'h202, 13'd8);
    doAppend(16'h0001, 4'h1, 12'h300, 13'd7);
    doAppend(16'h0001, 4'h1, 12'hFF8, 13'd8);
    doAppend(16'h0001, 4'h1, 12'hFF0, 13'd8);
    // R9 bad pointers
    mem[64] = {12'h142, 4'h1, 16'h0001};
    doSearch(16'h0005);
    mem[64] = {12'h0F0, 4'h1, 16'h0001};
    doSearch(16'h0005);
    mem[64] = {12'hFFC, 4'h1, 16'h0001};
    doSearch(16'h0005);
    doAppend(16'h0002, 4'h1, 12'h400, 13'd8);
    // R10 looped chain
    mem[64] = {12'h104, 4'h1, 16'h0001};
    mem[65] = {12'h100, 4'h1, 16'h0002};
    doSearch(16'h0009);

    // random chains
    for (int it = 0; it < 40; it++) begin
      clearMem();
      k = 1 + int'($urandom % 5);
      off = 256;
      last = 256;
      for (int i = 0; i < k; i++) begin
        id = 16'(1 + $urandom % 4);
        nxt = (i == k - 1) ? 0 : off + 8 + 4 * int'($urandom % 8);
        mem[off >> 2] = {12'(nxt), 4'($urandom), id};
        last = off;
        off = nxt;
      end
      doSearch(16'($urandom % 6));
      if ($urandom % 4 == 0)
        doAppend(16'(1 + $urandom % 4), 4'($urandom), 12'h100, 13'd8);
      else
        doAppend(16'(1 + $urandom % 4), 4'($urandom),
                 12'(last + 8 + 4 * int'($urandom % 16)), 13'(8 + $urandom % 16));
      doSearch(16'($urandom % 5));
      doSearch(16'h0000);
    end

    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule